// File: doc/BRIEF.md
# Pipelined Convergence Divider

This block divides an unsigned 16-bit numerator by an unsigned 16-bit denominator and returns an unsigned fixed-point quotient with 16 integer bits and 8 fraction bits. It does not subtract and shift like long division. It uses the convergence method instead. First the denominator is shifted left until its top bit is set, so that it reads as a fraction in [0.5, 1). After that, every step multiplies both the running numerator and the running denominator by the correction factor two minus the running denominator. The running denominator climbs towards one, and the running numerator climbs towards the quotient. A single right shift at the end, sized by the leading-zero count, undoes the normalisation.

Each convergence step is one pipeline stage. The number of steps, `ITERS`, can be set from 1 to 4. One step gives an error of at most a quarter. Each further step squares the remaining relative error and adds two wide multipliers. The pipeline accepts a new operand pair on every clock. Results leave in the order they arrived, `ITERS + 2` cycles after entry. A zero denominator does not stall the pipeline. It raises a flag beside the result and forces the quotient to all ones.

Top module: `gs_divider`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` and `out_dz` are low.
- R2: A pair presented with `in_valid` high on a rising edge gives `out_valid` high exactly `ITERS + 2` rising edges later. Pairs are accepted on consecutive cycles, and results come out in the same order.
- R3: The result stays within the bound of R5 for every leading-zero count of the denominator. Internally, the normalised denominator always has its top bit set.
- R4: The running denominator never falls and stays below one, and the running numerator never falls from one step to the next. As a result, for the same operands, the quotient with more steps is never smaller than the quotient with fewer steps.
- R5: For a nonzero denominator D and numerator N, let E = floor(N·256/D). The quotient Q satisfies E − (E >> 2^ITERS) − 4 ≤ Q ≤ E + 1.
- R6: A zero denominator gives `out_dz` = 1 and `out_quot` = all ones (24'hFFFFFF), whatever N is. `out_dz` is never high without `out_valid`.
- R7: A nonzero denominator gives `out_dz` = 0.
- R8: A zero numerator with a nonzero denominator gives `out_quot` = 0 exactly.
- R9: A cycle with `in_valid` low produces no result: `out_valid` is low `ITERS + 2` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_num | input | 16 | Unsigned numerator |
| in_den | input | 16 | Unsigned denominator |
| out_valid | output | 1 | Quotient present this cycle |
| out_quot | output | 24 | Unsigned quotient, 16 integer and 8 fraction bits |
| out_dz | output | 1 | Denominator of this result was zero |

## Verification
Some rules can be checked on every clock without knowing the true quotient, and assertions cover them. They check that the normalised denominator has its top bit set and that a zero denominator is flagged one stage later. They check that each step raises the running denominator and numerator and keeps the denominator below one. They also check that the flag always comes with a saturated quotient, that a zero running numerator comes out as zero, and that bubbles stay bubbles. Other properties need the exact answer, and only the bench scenarios can show them. These are the accuracy bound for each step count, the exact latency, the ordering of back-to-back results, and the fact that four steps never give less than one step. The bench compares four instances with one to four steps against integer division.

// File: rtl/gs_div_pkg.sv
`timescale 1ns/1ps
package gs_div_pkg;

    localparam int GS_W       = 16;
    localparam int GS_QF      = 8;
    localparam int GS_FB      = 24;
    localparam int GS_MAX_IT  = 4;
    localparam int GS_LZW     = $clog2(GS_W);
    localparam int GS_XW      = GS_W + 1 + GS_FB;
    localparam int GS_TW      = GS_FB + 1;
    localparam int GS_QW      = GS_W + GS_QF;
    localparam int GS_SHB     = GS_FB + GS_W - GS_QF;
    localparam int GS_SHW     = $clog2(GS_SHB + 1);

    typedef logic [GS_W-1:0]  gs_opnd_t;
    typedef logic [GS_QW-1:0] gs_quot_t;
    typedef logic [GS_XW-1:0] gs_num_t;
    typedef logic [GS_TW-1:0] gs_den_t;

    typedef struct packed {
        logic                vld;
        logic                dz;
        logic [GS_LZW-1:0]   lz;
        gs_num_t             x;
        gs_den_t             t;
    } gs_stage_t;

    function automatic logic [GS_LZW-1:0] gs_lead_zeros(input gs_opnd_t v);
        logic [GS_LZW:0] cnt;
        logic            seen;
        cnt  = '0;
        seen = 1'b0;
        for (int i = GS_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      cnt  = cnt + 1'b1;
            end
        end
        return cnt[GS_LZW-1:0];
    endfunction

    function automatic gs_den_t gs_correction(input gs_den_t t);
        logic [GS_TW:0] two;
        logic [GS_TW:0] diff;
        two  = (GS_TW+1)'(1) << (GS_FB + 1);
        diff = two - {1'b0, t};
        return diff[GS_TW-1:0];
    endfunction

    function automatic logic gs_unused_top(input logic b);
        return b;
    endfunction

endpackage

// File: rtl/gs_norm.sv
`timescale 1ns/1ps
module gs_norm
    import gs_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  gs_opnd_t  in_num,
    input  gs_opnd_t  in_den,
    output gs_stage_t st_o
);

    localparam int PADB = GS_FB - GS_W;

    gs_stage_t         st_q;
    gs_stage_t         nxt;
    logic [GS_LZW-1:0] lz;
    gs_opnd_t          dn;
    logic              zero_den;

    always_comb begin
        zero_den = (in_den == '0);
        lz       = gs_lead_zeros(in_den);
        dn       = in_den << lz;
        nxt.vld  = in_valid;
        nxt.dz   = in_valid && zero_den;
        nxt.lz   = lz;
        if (zero_den) begin
            nxt.x = '0;
            nxt.t = GS_TW'(1) << (GS_FB - 1);
        end else begin
            nxt.x = {1'b0, in_num, {GS_FB{1'b0}}};
            nxt.t = {1'b0, dn, {PADB{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= nxt;
    end

    assign st_o = st_q;

    a_r6_zero_flagged: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_den == '0) |=> st_q.vld && st_q.dz);

    a_r7_nonzero_clear: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_den != '0) |=> st_q.vld && !st_q.dz);

    a_r3_top_bit_set: assert property (@(posedge clk) disable iff (rst)
        st_q.vld && !st_q.dz |-> st_q.t[GS_FB-1] && !st_q.t[GS_FB]);

endmodule

// File: rtl/gs_iter.sv
`timescale 1ns/1ps
module gs_iter
    import gs_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gs_stage_t st_i,
    output gs_stage_t st_o
);

    localparam int PXW = GS_XW + GS_TW;
    localparam int PTW = 2 * GS_TW;

    gs_stage_t      st_q;
    gs_stage_t      nxt;
    gs_den_t        f;
    logic [PXW-1:0] px;
    logic [PTW-1:0] pt;

    always_comb begin
        f   = gs_correction(st_i.t);
        px  = {{GS_TW{1'b0}}, st_i.x} * {{GS_XW{1'b0}}, f};
        pt  = {{GS_TW{1'b0}}, st_i.t} * {{GS_TW{1'b0}}, f};
        nxt   = st_i;
        nxt.x = GS_XW'(px >> GS_FB);
        nxt.t = GS_TW'(pt >> GS_FB);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= nxt;
    end

    assign st_o = st_q;

    a_r4_den_rises: assert property (@(posedge clk) disable iff (rst)
        st_i.vld |=> (st_q.t >= $past(st_i.t)) && !st_q.t[GS_FB]);

    a_r4_num_rises: assert property (@(posedge clk) disable iff (rst)
        st_i.vld |=> st_q.x >= $past(st_i.x));

    a_r2_valid_moves: assert property (@(posedge clk) disable iff (rst)
        st_i.vld |=> st_q.vld);

endmodule

// File: rtl/gs_denorm.sv
`timescale 1ns/1ps
module gs_denorm
    import gs_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              dz,
    input  logic [GS_LZW-1:0] lz,
    input  gs_num_t           x,
    output logic              out_valid,
    output gs_quot_t          out_quot,
    output logic              out_dz
);

    logic [GS_SHW-1:0] sh;
    gs_num_t           qw;
    logic              ovf;
    gs_quot_t          q;

    always_comb begin
        sh  = GS_SHW'(GS_SHB - int'(lz));
        qw  = x >> sh;
        ovf = |(qw >> GS_QW);
        q   = (ovf || dz) ? '1 : GS_QW'(qw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dz    <= 1'b0;
            out_quot  <= '0;
        end else begin
            out_valid <= vld;
            out_dz    <= vld && dz;
            out_quot  <= vld ? q : '0;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid && !out_dz);

    a_r6_saturated: assert property (@(posedge clk) disable iff (rst)
        out_dz |-> out_valid && (&out_quot));

    a_r8_zero_num: assert property (@(posedge clk) disable iff (rst)
        vld && !dz && (x == '0) |=> out_quot == '0);

    a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
        !vld |=> !out_valid);

endmodule

// File: rtl/gs_divider.sv
`timescale 1ns/1ps
module gs_divider
    import gs_div_pkg::*;
#(
    parameter int ITERS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [GS_W-1:0]   in_num,
    input  logic [GS_W-1:0]   in_den,
    output logic              out_valid,
    output logic [GS_QW-1:0]  out_quot,
    output logic              out_dz
);

    gs_stage_t chain [ITERS+1];

    generate
        if (ITERS < 1 || ITERS > GS_MAX_IT) begin : g_bad_cfg
            $error("ITERS must lie between 1 and %0d", GS_MAX_IT);
        end
    endgenerate

    gs_norm u_norm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_num   (in_num),
        .in_den   (in_den),
        .st_o     (chain[0])
    );

    for (genvar i = 0; i < ITERS; i++) begin : g_step
        gs_iter u_step (
            .clk  (clk),
            .rst  (rst),
            .st_i (chain[i]),
            .st_o (chain[i+1])
        );
    end

    gs_denorm u_out (
        .clk       (clk),
        .rst       (rst),
        .vld       (chain[ITERS].vld),
        .dz        (chain[ITERS].dz),
        .lz        (chain[ITERS].lz),
        .x         (chain[ITERS].x),
        .out_valid (out_valid),
        .out_quot  (out_quot),
        .out_dz    (out_dz)
    );

    a_r4_final_den_range: assert property (@(posedge clk) disable iff (rst)
        chain[ITERS].vld |-> chain[ITERS].t[GS_FB-1] && !chain[ITERS].t[GS_FB]);

endmodule

// File: tb/sim_gs_divider.sv
`timescale 1ns/1ps
module sim_gs_divider;

    localparam int NINST = 4;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_num = '0;
    logic [15:0] in_den = '0;

    logic        ov  [NINST];
    logic [23:0] oq  [NINST];
    logic        odz [NINST];

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    longint      cyc = 0;

    logic [15:0] vn [DEPTH];
    logic [15:0] vd [DEPTH];
    longint      in_cyc [DEPTH];
    logic [23:0] got_q   [NINST][DEPTH];
    logic        got_dz  [NINST][DEPTH];
    longint      got_cyc [NINST][DEPTH];
    int          cnt [NINST];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    gs_divider #(.ITERS(3)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_num(in_num), .in_den(in_den), .out_valid(ov[0]), .out_quot(oq[0]), .out_dz(odz[0]));
    gs_divider #(.ITERS(1)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_num(in_num), .in_den(in_den), .out_valid(ov[1]), .out_quot(oq[1]), .out_dz(odz[1]));
    gs_divider #(.ITERS(2)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_num(in_num), .in_den(in_den), .out_valid(ov[2]), .out_quot(oq[2]), .out_dz(odz[2]));
    gs_divider #(.ITERS(4)) u3 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_num(in_num), .in_den(in_den), .out_valid(ov[3]), .out_quot(oq[3]), .out_dz(odz[3]));

    function automatic int iters_of(input int k);
        case (k)
            0: return 3;
            1: return 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    always @(negedge clk) begin
        for (int k = 0; k < NINST; k++) begin
            if (!rst && ov[k] && cnt[k] < DEPTH) begin
                got_q[k][cnt[k]]   = oq[k];
                got_dz[k][cnt[k]]  = odz[k];
                got_cyc[k][cnt[k]] = cyc;
                cnt[k] = cnt[k] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Drive n pairs, with gap idle cycles after each, then check every instance.
    task automatic run_batch(input int n, input int gap, input string req_acc);
        for (int k = 0; k < NINST; k++) cnt[k] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_num    = vn[i];
            in_den    = vd[i];
            in_cyc[i] = cyc;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < NINST; k++) begin
            int it = iters_of(k);
            check(cnt[k] == n, (gap > 0) ? "R9 result count" : "R2 result count", cnt[k], n);
            for (int i = 0; i < n && i < cnt[k]; i++) begin
                longint e;
                longint lo;
                longint hi;
                check(got_cyc[k][i] - in_cyc[i] == longint'(it + 2), "R2 latency",
                      got_cyc[k][i] - in_cyc[i], it + 2);
                if (vd[i] == 16'd0) begin
                    check(got_dz[k][i] == 1'b1, "R6 flag", got_dz[k][i], 1);
                    check(got_q[k][i] == 24'hFFFFFF, "R6 saturate", got_q[k][i], 24'hFFFFFF);
                end else begin
                    e  = (longint'(vn[i]) << 8) / longint'(vd[i]);
                    lo = e - (e >> (1 << it)) - 4;
                    hi = e + 1;
                    check(got_dz[k][i] == 1'b0, "R7 flag clear", got_dz[k][i], 0);
                    check(longint'(got_q[k][i]) >= lo && longint'(got_q[k][i]) <= hi,
                          req_acc, got_q[k][i], e);
                    if (vn[i] == 16'd0)
                        check(got_q[k][i] == 24'd0, "R8 zero numerator", got_q[k][i], 0);
                end
            end
        end
        // R4: four steps never give less than one step (index 3 vs index 1)
        for (int i = 0; i < n && i < cnt[3] && i < cnt[1]; i++) begin
            if (vd[i] != 16'd0)
                check(got_q[3][i] >= got_q[1][i], "R4 more steps not smaller",
                      got_q[3][i], got_q[1][i]);
        end
    endtask

    task automatic t_reset();
        for (int k = 0; k < NINST; k++)
            check(!ov[k] && !odz[k], "R1 during reset", ov[k], 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NINST; k++)
            check(!ov[k] && !odz[k], "R1 after reset", ov[k], 0);
    endtask

    task automatic t_mixed();
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            vn[i] = s[31:16];
            s = s * 32'd1664525 + 32'd1013904223;
            vd[i] = (s[31:16] == 16'd0) ? 16'd7 : s[31:16];
        end
        run_batch(40, 0, "R5 accuracy random");
    endtask

    task automatic t_shift_sweep();
        // one denominator for every leading-zero count (R3)
        for (int i = 0; i < 16; i++) begin
            vn[i] = 16'hBEEF ^ 16'(i * 977);
            vd[i] = 16'(16'h8000 >> i) | 16'(16'h5A5A >> (i + 1));
        end
        run_batch(16, 0, "R3 accuracy per shift");
    endtask

    task automatic t_extremes();
        vn[0] = 16'hFFFF; vd[0] = 16'd1;
        vn[1] = 16'd1;    vd[1] = 16'hFFFF;
        vn[2] = 16'hFFFF; vd[2] = 16'hFFFF;
        vn[3] = 16'd1000; vd[3] = 16'd1000;
        vn[4] = 16'd3;    vd[4] = 16'd3;
        vn[5] = 16'hFFFF; vd[5] = 16'h8000;
        vn[6] = 16'hFFFF; vd[6] = 16'h7FFF;
        vn[7] = 16'd100;  vd[7] = 16'd3;
        run_batch(8, 0, "R5 accuracy extremes");
    endtask

    task automatic t_zero_den();
        vn[0] = 16'd0;    vd[0] = 16'd0;
        vn[1] = 16'hFFFF; vd[1] = 16'd0;
        vn[2] = 16'd500;  vd[2] = 16'd9;
        vn[3] = 16'd123;  vd[3] = 16'd0;
        vn[4] = 16'd77;   vd[4] = 16'd2;
        run_batch(5, 0, "R5 accuracy near zero denominator");
    endtask

    task automatic t_zero_num();
        vn[0] = 16'd0; vd[0] = 16'd1;
        vn[1] = 16'd0; vd[1] = 16'hFFFF;
        vn[2] = 16'd0; vd[2] = 16'd300;
        run_batch(3, 0, "R5 accuracy zero numerator");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 6; i++) begin
            vn[i] = 16'(1000 + i * 4111);
            vd[i] = 16'(3 + i * 1501);
        end
        run_batch(6, 2, "R5 accuracy with gaps");
    endtask

    initial begin
        for (int k = 0; k < NINST; k++) cnt[k] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_mixed();
        t_shift_sweep();
        t_extremes();
        t_zero_den();
        t_zero_num();
        t_bubbles();
        summary();
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

endmodule